// File: doc/BRIEF.md
# SPI Master Interrupt Status Unit

This block collects the interrupt conditions of a byte-oriented SPI master and turns them into one level-sensitive interrupt line. Three conditions are events: a TX FIFO underflow, an RX FIFO overflow and a mode failure. Each arrives as a one-cycle pulse and is latched until software clears it. The other four conditions track the FIFOs continuously: the two full flags, the RX count reaching its threshold and the TX count falling below its threshold. The FIFOs, the serial shifter and the chip-select logic sit outside this block. It only sees their counts, flags and pulses.

Software reaches the block through a small write port. One address clears latched event bits when a 1 is written to them. Two further addresses set or clear bits of the interrupt mask, so the mask is never written as a whole word. The last two addresses load the TX and RX thresholds. When the controller runs in linear (memory-mapped read) mode, an input freezes the status word so that background flash fetches cannot disturb it.

Top module: `spi_irq_status_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `status_o`, `mask_o` and `irq_o` become 0 and both thresholds become 1.
- R2: Status bit 6 (TX underflow), bit 1 (mode fail) and bit 0 (RX overflow) are sticky. A high `ev_tx_underflow_i`, `ev_mode_fail_i` or `ev_rx_overflow_i` at an edge sets the bit, and the bit then holds until software clears it.
- R3: A write with `wr_addr_i` = 0 clears each sticky status bit whose `wr_data_i` bit is 1 and leaves the other sticky bits as they are. If an event and a clear hit the same bit at the same edge, the bit ends up set.
- R4: Status bit 5 equals `rx_full_i` and status bit 3 equals `tx_full_i`, both as sampled at the previous edge.
- R5: Status bit 4 is 1 when `rx_count_i` >= RX threshold. Status bit 2 is 1 when `tx_count_i` < TX threshold. A write with `wr_addr_i` = 3 loads the TX threshold and a write with `wr_addr_i` = 4 loads the RX threshold, each from `wr_data_i[CNT_W-1:0]`. A new threshold takes part in the compare from the edge after the one that loads it.
- R6: A write with `wr_addr_i` = 1 ORs `wr_data_i[6:0]` into the mask. A write with `wr_addr_i` = 2 clears the mask bits written as 1. No other write changes the mask.
- R7: `irq_o` is a register. At each edge it takes the OR of (`status_o` AND `mask_o`) as they stood before that edge.
- R8: While `lin_mode_i` is high, `status_o` holds its value. Events, FIFO inputs and clearing writes all leave it unchanged.
- R9: Only `wr_data_i[6:0]` acts on status and mask. Higher data bits have no effect, and writes with `wr_addr_i` 5 to 7 change nothing. Writing 1 to a live bit (2 to 5) through address 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lin_mode_i | input | 1 | Linear read mode active; freezes status |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_full_i | input | 1 | TX FIFO full |
| rx_full_i | input | 1 | RX FIFO full |
| ev_tx_underflow_i | input | 1 | TX underflow event pulse |
| ev_rx_overflow_i | input | 1 | RX overflow event pulse |
| ev_mode_fail_i | input | 1 | Mode fail event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write target: 0 clear status, 1 set mask, 2 clear mask, 3 TX threshold, 4 RX threshold |
| wr_data_i | input | DATA_W | Write data |
| status_o | output | 7 | Status word |
| mask_o | output | 7 | Interrupt mask |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: CNT_W = 7 and DATA_W = 32. A 7-bit count spans a 64-entry FIFO from empty to full, so thresholds of 1 and 64 can be tried against counts of 63 and 64, which are the exact boundaries of both compares. The 32-bit data port leaves 25 bits above the status field, and the bench drives those bits high to show they are ignored.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the SPI interrupt status unit.
// Assumes a 7-bit status word; bit positions are fixed because
// software decodes them.
package spi_irq_pkg;
    localparam int IRQ_W = 7;

    localparam int B_RX_OVF    = 0;
    localparam int B_MODE_FAIL = 1;
    localparam int B_TX_BELOW  = 2;
    localparam int B_TX_FULL   = 3;
    localparam int B_RX_AT     = 4;
    localparam int B_RX_FULL   = 5;
    localparam int B_TX_UNF    = 6;

    // Positions latched by events and cleared by software.
    localparam logic [IRQ_W-1:0] STICKY_BITS = 7'b100_0011;

    typedef enum logic [2:0] {
        SEL_STATUS_CLR = 3'd0,
        SEL_MASK_SET   = 3'd1,
        SEL_MASK_CLR   = 3'd2,
        SEL_TX_THR     = 3'd3,
        SEL_RX_THR     = 3'd4
    } wr_sel_e;
endpackage

// File: rtl/spi_irq_thresh.sv
// Holds the TX and RX threshold registers.
// Assumes the write strobes are already decoded and at most one is high.
module spi_irq_thresh #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tx_i,
    input  logic             wr_rx_i,
    input  logic [CNT_W-1:0] data_i,
    output logic [CNT_W-1:0] tx_thr_o,
    output logic [CNT_W-1:0] rx_thr_o
);
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);

    // Load a threshold on its write strobe; reset both to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_o <= THR_RST;
            rx_thr_o <= THR_RST;
        end else begin
            if (wr_tx_i) tx_thr_o <= data_i;
            if (wr_rx_i) rx_thr_o <= data_i;
        end
    end
endmodule

// File: rtl/spi_irq_status.sv
// Status word register: sticky event bits plus live FIFO compare bits.
// Assumes the event vector is zero outside the sticky positions; a
// freeze input holds the whole word (linear mode).
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] tx_thr_i,
    input  logic [CNT_W-1:0] rx_thr_i,
    input  logic             tx_full_i,
    input  logic             rx_full_i,
    input  logic [IRQ_W-1:0] event_i,
    input  logic [IRQ_W-1:0] clear_i,
    output logic [IRQ_W-1:0] status_o
);
    logic [IRQ_W-1:0] live;
    logic [IRQ_W-1:0] nxt;
    logic [IRQ_W-1:0] unused_live_in;

    // Evaluate the FIFO-derived conditions.
    always_comb begin
        live              = '0;
        live[B_RX_FULL]   = rx_full_i;
        live[B_TX_FULL]   = tx_full_i;
        live[B_RX_AT]     = (rx_count_i >= rx_thr_i);
        live[B_TX_BELOW]  = (tx_count_i < tx_thr_i);
    end

    // Pick the next value per bit: latch-and-clear or follow live.
    for (genvar g = 0; g < IRQ_W; g++) begin : g_bit
        if (STICKY_BITS[g]) begin : g_sticky
            assign nxt[g] = (status_o[g] & ~clear_i[g]) | event_i[g];
        end else begin : g_live
            assign nxt[g] = live[g];
        end
    end

    assign unused_live_in = (event_i | clear_i) & ~STICKY_BITS;

    // Update the word unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_o <= '0;
        else if (!freeze_i) status_o <= nxt;
    end
endmodule

// File: rtl/spi_irq_mask.sv
// Interrupt mask reached only through set-only and clear-only writes.
// Assumes set and clear strobes are never high together.
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [IRQ_W-1:0] data_i,
    output logic [IRQ_W-1:0] mask_o
);
    // Apply OR-in or clear-out of the written bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_o <= '0;
        else if (set_i) mask_o <= mask_o | data_i;
        else if (clr_i) mask_o <= mask_o & ~data_i;
    end
endmodule

// File: rtl/spi_irq_status_unit.sv
// Top of the SPI interrupt status unit: decodes the write port, holds
// thresholds, status and mask, and drives a registered level interrupt.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module spi_irq_status_unit
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lin_mode_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic              tx_full_i,
    input  logic              rx_full_i,
    input  logic              ev_tx_underflow_i,
    input  logic              ev_rx_overflow_i,
    input  logic              ev_mode_fail_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [IRQ_W-1:0]  status_o,
    output logic [IRQ_W-1:0]  mask_o,
    output logic              irq_o
);
    logic             wr_stat, wr_mset, wr_mclr, wr_txt, wr_rxt;
    logic [IRQ_W-1:0] ev_vec;
    logic [CNT_W-1:0] tx_thr, rx_thr;
    logic             unused_wr_data;

    // Decode the write target.
    always_comb begin
        wr_stat = wr_en_i && (wr_addr_i == SEL_STATUS_CLR);
        wr_mset = wr_en_i && (wr_addr_i == SEL_MASK_SET);
        wr_mclr = wr_en_i && (wr_addr_i == SEL_MASK_CLR);
        wr_txt  = wr_en_i && (wr_addr_i == SEL_TX_THR);
        wr_rxt  = wr_en_i && (wr_addr_i == SEL_RX_THR);
    end

    // Place event pulses at their status positions.
    always_comb begin
        ev_vec              = '0;
        ev_vec[B_TX_UNF]    = ev_tx_underflow_i;
        ev_vec[B_MODE_FAIL] = ev_mode_fail_i;
        ev_vec[B_RX_OVF]    = ev_rx_overflow_i;
    end

    assign unused_wr_data = ^wr_data_i;

    spi_irq_thresh #(.CNT_W(CNT_W)) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_tx_i  (wr_txt),
        .wr_rx_i  (wr_rxt),
        .data_i   (wr_data_i[CNT_W-1:0]),
        .tx_thr_o (tx_thr),
        .rx_thr_o (rx_thr)
    );

    spi_irq_status #(.CNT_W(CNT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze_i   (lin_mode_i),
        .tx_count_i (tx_count_i),
        .rx_count_i (rx_count_i),
        .tx_thr_i   (tx_thr),
        .rx_thr_i   (rx_thr),
        .tx_full_i  (tx_full_i),
        .rx_full_i  (rx_full_i),
        .event_i    (ev_vec),
        .clear_i    (wr_stat ? wr_data_i[IRQ_W-1:0] : '0),
        .status_o   (status_o)
    );

    spi_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_mset),
        .clr_i  (wr_mclr),
        .data_i (wr_data_i[IRQ_W-1:0]),
        .mask_o (mask_o)
    );

    // Register the interrupt level from status and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status_o & mask_o);
    end
endmodule

// File: rtl/spi_irq_status_unit_chk.sv
// Property checker for the SPI interrupt status unit, bound to the top.
// Assumes synchronous active-low reset; past_ok gates every $past use.
module spi_irq_status_unit_chk
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lin_mode_i,
    input logic              rx_full_i,
    input logic              ev_tx_underflow_i,
    input logic              ev_mode_fail_i,
    input logic              ev_rx_overflow_i,
    input logic              wr_en_i,
    input logic [2:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [IRQ_W-1:0]  status_o,
    input logic [IRQ_W-1:0]  mask_o,
    input logic              irq_o
);
    logic past_ok;

    // Mark edges whose previous edge was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(status_o & mask_o))));

    // R8
    linear_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(lin_mode_i)) |-> $stable(status_o));

    // R2
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(lin_mode_i) && $past(ev_tx_underflow_i)) |-> status_o[B_TX_UNF]);

    // R3
    modefail_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(lin_mode_i) && $past(ev_mode_fail_i)) |-> status_o[B_MODE_FAIL]);

    // R2
    overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(status_o[B_RX_OVF]) &&
         !$past(wr_en_i && wr_addr_i == 3'd0 && wr_data_i[B_RX_OVF])) |-> status_o[B_RX_OVF]);

    // R4
    rx_full_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(lin_mode_i)) |-> (status_o[B_RX_FULL] == $past(rx_full_i)));

    // R6
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_en_i && (wr_addr_i == 3'd1 || wr_addr_i == 3'd2))) |-> $stable(mask_o));

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en_i && wr_addr_i == 3'd1)) |->
        ((mask_o & $past(wr_data_i[IRQ_W-1:0])) == $past(wr_data_i[IRQ_W-1:0])));
endmodule

bind spi_irq_status_unit spi_irq_status_unit_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .lin_mode_i        (lin_mode_i),
    .rx_full_i         (rx_full_i),
    .ev_tx_underflow_i (ev_tx_underflow_i),
    .ev_mode_fail_i    (ev_mode_fail_i),
    .ev_rx_overflow_i  (ev_rx_overflow_i),
    .wr_en_i           (wr_en_i),
    .wr_addr_i         (wr_addr_i),
    .wr_data_i         (wr_data_i),
    .status_o          (status_o),
    .mask_o            (mask_o),
    .irq_o             (irq_o)
);

// File: tb/spi_irq_status_unit_tb.sv
// Scoreboard bench: the driver applies one cycle of stimulus, updates a
// reference model built from the requirements and queues the expected
// outputs; the monitor compares them after the following edge.
module spi_irq_status_unit_tb;
    localparam int CNT_W  = 7;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lin_mode_i = 1'b0;
    logic [CNT_W-1:0]  tx_count_i = '0;
    logic [CNT_W-1:0]  rx_count_i = '0;
    logic              tx_full_i = 1'b0;
    logic              rx_full_i = 1'b0;
    logic              ev_tx_underflow_i = 1'b0;
    logic              ev_rx_overflow_i = 1'b0;
    logic              ev_mode_fail_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [2:0]        wr_addr_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [6:0]        status_o;
    logic [6:0]        mask_o;
    logic              irq_o;

    always #4 clk = ~clk;

    spi_irq_status_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (.*);

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    logic [6:0]       m_status = '0, m_mask = '0;
    logic [CNT_W-1:0] m_txthr = 1, m_rxthr = 1;
    logic             m_irq = 1'b0;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string tag, string what, logic [6:0] got, logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One cycle of stimulus plus the model update for that edge.
    task automatic drive(string tag, logic lin, int txc, int rxc, logic txf, logic rxf,
                         logic unf, logic ovf, logic mf,
                         logic we, logic [2:0] addr, logic [DATA_W-1:0] data);
        logic [6:0] ns;
        logic [6:0] clr;
        @(negedge clk);
        lin_mode_i = lin; tx_count_i = CNT_W'(txc); rx_count_i = CNT_W'(rxc);
        tx_full_i = txf; rx_full_i = rxf;
        ev_tx_underflow_i = unf; ev_rx_overflow_i = ovf; ev_mode_fail_i = mf;
        wr_en_i = we; wr_addr_i = addr; wr_data_i = data;
        m_irq = |(m_status & m_mask);
        clr = (we && addr == 3'd0) ? data[6:0] : 7'd0;
        if (!lin) begin
            ns[6] = (m_status[6] & ~clr[6]) | unf;
            ns[1] = (m_status[1] & ~clr[1]) | mf;
            ns[0] = (m_status[0] & ~clr[0]) | ovf;
            ns[5] = rxf;
            ns[3] = txf;
            ns[4] = (CNT_W'(rxc) >= m_rxthr);
            ns[2] = (CNT_W'(txc) < m_txthr);
            m_status = ns;
        end
        if (we && addr == 3'd1) m_mask = m_mask | data[6:0];
        if (we && addr == 3'd2) m_mask = m_mask & ~data[6:0];
        if (we && addr == 3'd3) m_txthr = data[CNT_W-1:0];
        if (we && addr == 3'd4) m_rxthr = data[CNT_W-1:0];
        exp_q.push_back({m_irq, m_mask, m_status});
        tag_q.push_back(tag);
    endtask

    task automatic idle(string tag, int txc, int rxc);
        drive(tag, 0, txc, rxc, 0, 0, 0, 0, 0, 0, 3'd0, '0);
    endtask

    task automatic wr(string tag, logic [2:0] addr, logic [DATA_W-1:0] data);
        drive(tag, 0, 1, 0, 0, 0, 0, 0, 0, 1, addr, data);
    endtask

    // Monitor: compare after each edge once items are queued.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [14:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "status", status_o, e[6:0]);
                check(t, "mask", mask_o, e[13:7]);
                check(t, "irq", {6'd0, irq_o}, {6'd0, e[14]});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports
        check("R1", "status", status_o, 7'h00);
        check("R1", "mask", mask_o, 7'h00);
        check("R1", "irq", {6'd0, irq_o}, 7'h00);

        idle("R1_thr_reset", 0, 0);           // TX 0 < 1 sets bit 2
        idle("R5_rx_at", 1, 1);               // RX 1 >= 1 sets bit 4
        drive("R4_full", 0, 1, 0, 1, 1, 0, 0, 0, 0, 3'd0, '0);
        drive("R4_rx_only", 0, 1, 0, 0, 1, 0, 0, 0, 0, 3'd0, '0);
        idle("R4_clear", 1, 0);

        drive("R2_underflow", 0, 1, 0, 0, 0, 1, 0, 0, 0, 3'd0, '0);
        idle("R2_hold", 1, 0);
        drive("R2_overflow", 0, 1, 0, 0, 0, 0, 1, 0, 0, 3'd0, '0);
        drive("R2_modefail", 0, 1, 0, 0, 0, 0, 0, 1, 0, 3'd0, '0);
        idle("R2_hold_all", 1, 0);

        wr("R6_mask_set", 3'd1, 32'h0000_0040);
        idle("R7_irq_rise", 1, 0);
        idle("R7_irq_high", 1, 0);
        wr("R3_clear_unf", 3'd0, 32'h0000_0040);
        idle("R7_irq_fall", 1, 0);
        idle("R3_other_kept", 1, 0);

        drive("R3_event_wins", 0, 1, 0, 0, 0, 0, 0, 1, 1, 3'd0, 32'h0000_0003);
        idle("R3_after_race", 1, 0);
        drive("R9_live_w1c", 0, 0, 1, 1, 1, 0, 0, 0, 1, 3'd0, 32'h0000_003C);

        wr("R5_tx_thr64", 3'd3, 32'd64);
        idle("R5_tx_63", 63, 0);
        idle("R5_tx_64", 64, 0);
        wr("R5_rx_thr64", 3'd4, 32'd64);
        idle("R5_rx_63", 0, 63);
        idle("R5_rx_64", 0, 64);

        wr("R6_mask_set_more", 3'd1, 32'h0000_0013);
        idle("R7_irq_more", 0, 64);
        wr("R6_mask_clr", 3'd2, 32'h0000_0012);
        idle("R6_after_clr", 0, 64);

        drive("R8_freeze_ev", 1, 10, 10, 1, 1, 1, 1, 1, 0, 3'd0, '0);
        drive("R8_freeze_w1c", 1, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'h0000_007F);
        idle("R8_unfreeze", 0, 0);

        wr("R9_addr5", 3'd5, 32'hFFFF_FFFF);
        wr("R9_addr7", 3'd7, 32'hFFFF_FFFF);
        wr("R9_high_bits", 3'd1, 32'hFFFF_FF80);
        wr("R9_high_clr", 3'd2, 32'hFFFF_FF80);
        idle("R7_final", 1, 0);

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule